// File: doc/BRIEF.md
# Looping Register Address Sequencer with Serial Slave Front End

This block is the serial slave side of a two-channel data converter's register map. The bus master lowers chip select and sends one control byte. That byte carries a register address and a read/write flag. From then on, an internal address counter picks the register for every following byte. Read data goes out on MISO and write data comes in on MOSI. No further command bytes are needed until chip select rises again. The serial pins are sampled with the system clock through synchronizers, so SCK must run well below the system clock.

The map has sixteen byte registers. Channel 0 data sits at 0x00..0x02 (upper, middle, lower) with a reserved byte at 0x03. Channel 1 data sits at 0x04..0x06 with a reserved byte at 0x07. Four configuration bytes occupy 0x08..0x0B and four calibration bytes occupy 0x0C..0x0F. The byte at 0x08 holds the loop mode and the two channel width bits. Together they decide how the counter steps and which bytes it leaves out. A load strobe copies both channel sample inputs into their data holders.

Top module: `loop_seq_spi`

## Requirements
- R1: The control byte is shifted in MSB first, sampled on rising SCK. Bits [4:1] give the register address, bits [7:5] are ignored and bit 0 = 1 selects read. Read data leaves on MISO MSB first, changing on falling SCK (SPI mode 0).
- R2: In a read, the byte after the control byte is the register at the command address. Each later byte comes from the address counter with no new command.
- R3: Loop mode 00 (byte 0x08 bits [7:6]) holds the address, so the same register repeats.
- R4: Loop mode 01 increments the address and wraps inside its aligned 4-byte group (0x00-0x03, 0x04-0x07, 0x08-0x0B, 0x0C-0x0F).
- R5: Loop mode 10 increments the address and wraps inside its type: channel data 0x00-0x07, configuration 0x08-0x0B, calibration 0x0C-0x0F.
- R6: Loop mode 11 increments the address across the whole map, wrapping from 0x0F to 0x00.
- R7: Byte 0x08 bit 1 is the channel 0 width and bit 0 the channel 1 width (1 = 24-bit, 0 = 16-bit). In any incrementing mode, a 16-bit channel's lower byte (0x02 or 0x06) is stepped over.
- R8: In any incrementing mode, the reserved bytes 0x03 and 0x07 are stepped over.
- R9: After reset, byte 0x08 reads 0x80, all other registers read 0x00, and MISO is 0.
- R10: In a write, each byte after the control byte is stored at the counter address. A value written to 0x08 governs the step taken right after that byte.
- R11: Writes to channel data addresses 0x00-0x07 are ignored, but the counter still advances past them.
- R12: Raising chip select ends the transfer and clears the serial state. A partly shifted byte is discarded, and the next transfer starts with a control byte.
- R13: A high sample_load copies ch0_sample and ch1_sample into the data holders. The upper byte is sample bits [23:16], the middle [15:8] and the lower [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 while deselected |
| sample_load | input | 1 | Capture strobe for both channel holders |
| ch0_sample | input | 24 | Channel 0 converter result |
| ch1_sample | input | 24 | Channel 1 converter result |

## Verification
A wrong address counter or a wrong wrap decision shows on MISO in the very next byte, one byte time (eight SCK periods) after the faulty step. The stream then repeats the error on every pass of the loop. A corrupted configuration byte shows as a wrong loop length or a wrong skip of a lower or reserved byte within one pass of the loop. A bad bit counter misframes the data, so every later byte of the transfer reads shifted. Each of these appears within a few bytes, because every test streams at least six bytes per command.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int BYTE_W   = 8;
    localparam int CH_BYTES = 3;
    localparam int SAMPLE_W = BYTE_W * CH_BYTES;
    localparam int ADDR_W   = 4;
    localparam int CH_NUM   = 2;
    localparam int RW_NUM   = 8;
    localparam int MAX_HOPS = 3;

    localparam logic [ADDR_W-1:0] CFG_ADDR = 4'h8;

    typedef enum logic [1:0] {
        LOOP_HOLD  = 2'b00,
        LOOP_GROUP = 2'b01,
        LOOP_TYPE  = 2'b10,
        LOOP_MAP   = 2'b11
    } loop_mode_e;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // One increment inside the window chosen by the loop mode.
    function automatic logic [ADDR_W-1:0] wrap_inc(input logic [ADDR_W-1:0] a,
                                                   input loop_mode_e m);
        logic [ADDR_W-1:0] mask;
        case (m)
            LOOP_GROUP: mask = 4'h3;
            LOOP_TYPE:  mask = a[3] ? 4'h3 : 4'h7;
            LOOP_MAP:   mask = 4'hF;
            default:    mask = 4'h0;
        endcase
        return (a & ~mask) | ((a + 4'h1) & mask);
    endfunction

    // Reserved bytes and lower bytes of 16-bit channels are never presented.
    function automatic logic is_skipped(input logic [ADDR_W-1:0] a,
                                        input logic w0, input logic w1);
        return (a == 4'h3) || (a == 4'h7) ||
               ((a == 4'h2) && !w0) || ((a == 4'h6) && !w1);
    endfunction

endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/lrs_addr_step.sv
module lrs_addr_step
    import lrs_pkg::*;
(
    input  logic [ADDR_W-1:0] cur_addr,
    input  loop_mode_e        mode,
    input  logic              w0,
    input  logic              w1,
    output logic [ADDR_W-1:0] next_addr
);
    always_comb begin
        logic [ADDR_W-1:0] a;
        logic              found;
        a     = cur_addr;
        found = (mode == LOOP_HOLD);
        for (int hop = 0; hop < MAX_HOPS; hop++) begin
            if (!found) begin
                a = wrap_inc(a, mode);
                if (!is_skipped(a, w0, w1)) found = 1'b1;
            end
        end
        next_addr = a;
    end
endmodule

// File: rtl/lrs_regfile.sv
module lrs_regfile
    import lrs_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CFG_RESET = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] ch0_in,
    input  logic [SAMPLE_W-1:0] ch1_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    output loop_mode_e          mode,
    output logic                w0,
    output logic                w1
);
    logic [SAMPLE_W-1:0] hold_q [CH_NUM];
    logic [BYTE_W-1:0]   rw_q   [RW_NUM];
    logic [SAMPLE_W-1:0] ch_in  [CH_NUM];

    assign ch_in[0] = ch0_in;
    assign ch_in[1] = ch1_in;

    for (genvar c = 0; c < CH_NUM; c++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hold_q[c] <= '0;
            else if (load) hold_q[c] <= ch_in[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RW_NUM; i++) rw_q[i] <= (i == 0) ? CFG_RESET : '0;
        end else if (wr_en && wr_addr[3]) begin
            rw_q[wr_addr[2:0]] <= wr_data;
        end
    end

    always_comb begin
        logic [SAMPLE_W-1:0] h;
        h = hold_q[rd_addr[2]];
        if (rd_addr[3]) begin
            rd_data = rw_q[rd_addr[2:0]];
        end else begin
            case (rd_addr[1:0])
                2'd0:    rd_data = h[23:16];
                2'd1:    rd_data = h[15:8];
                2'd2:    rd_data = h[7:0];
                default: rd_data = '0;
            endcase
        end
    end

    assign mode = loop_mode_e'(rw_q[0][7:6]);
    assign w0   = rw_q[0][1];
    assign w1   = rw_q[0][0];
endmodule

// File: rtl/loop_seq_spi.sv
module loop_seq_spi
    import lrs_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] CFG_RESET   = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sck,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic                sample_load,
    input  logic [SAMPLE_W-1:0] ch0_sample,
    input  logic [SAMPLE_W-1:0] ch1_sample
);
    localparam int BIT_W = $clog2(BYTE_W);

    typedef struct packed {
        phase_e              phase;
        logic [BIT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   rx;
        logic [BYTE_W-1:0]   tx;
        logic                sdo;
        logic [ADDR_W-1:0]   addr;
        logic                rd;
        logic                sck_prev;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    logic [2:0]        pins_s;
    logic              cs_s, sck_s, sdi_s;
    logic              rise, fall, byte_done;
    logic [BYTE_W-1:0] byte_in;
    logic [ADDR_W-1:0] step_next, rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic              wr_en;
    loop_mode_e        cfg_mode, eff_mode;
    logic              cfg_w0, cfg_w1, eff_w0, eff_w1, cfg_write;

    lrs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sck, spi_mosi}),
        .dout (pins_s)
    );
    assign {cs_s, sck_s, sdi_s} = pins_s;

    lrs_regfile #(.CFG_RESET(CFG_RESET)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sample_load),
        .ch0_in (ch0_sample),
        .ch1_in (ch1_sample),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .mode   (cfg_mode),
        .w0     (cfg_w0),
        .w1     (cfg_w1)
    );

    lrs_addr_step u_step (
        .cur_addr (st_q.addr),
        .mode     (eff_mode),
        .w0       (eff_w0),
        .w1       (eff_w1),
        .next_addr(step_next)
    );

    assign rise      = !cs_s && sck_s && !st_q.sck_prev;
    assign fall      = !cs_s && !sck_s && st_q.sck_prev;
    assign byte_in   = {st_q.rx[BYTE_W-2:0], sdi_s};
    assign byte_done = rise && (st_q.bit_cnt == BIT_W'(BYTE_W - 1));

    // A byte being written to the config register steers the step after it.
    assign cfg_write = (st_q.phase == PH_DATA) && !st_q.rd && (st_q.addr == CFG_ADDR);
    assign eff_mode  = cfg_write ? loop_mode_e'(byte_in[7:6]) : cfg_mode;
    assign eff_w0    = cfg_write ? byte_in[1] : cfg_w0;
    assign eff_w1    = cfg_write ? byte_in[0] : cfg_w1;

    assign rd_addr = (st_q.phase == PH_CMD) ? byte_in[4:1] : step_next;
    assign wr_addr = st_q.addr;
    assign wr_data = byte_in;

    always_comb begin
        st_d          = st_q;
        wr_en         = 1'b0;
        st_d.sck_prev = sck_s;
        if (cs_s) begin
            st_d.phase   = PH_CMD;
            st_d.bit_cnt = '0;
            st_d.rx      = '0;
            st_d.tx      = '0;
            st_d.sdo     = 1'b0;
        end else if (rise) begin
            st_d.rx      = byte_in;
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (byte_done) begin
                if (st_q.phase == PH_CMD) begin
                    st_d.phase = PH_DATA;
                    st_d.addr  = byte_in[4:1];
                    st_d.rd    = byte_in[0];
                    st_d.tx    = byte_in[0] ? rd_data : '0;
                end else begin
                    wr_en     = !st_q.rd;
                    st_d.addr = step_next;
                    st_d.tx   = st_q.rd ? rd_data : '0;
                end
            end
        end else if (fall) begin
            st_d.sdo = st_q.tx[BYTE_W-1];
            st_d.tx  = {st_q.tx[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_CMD, default: '0};
        else        st_q <= st_d;
    end

    assign spi_miso = st_q.sdo && !cs_s;
endmodule

// File: rtl/loop_seq_spi_chk.sv
module loop_seq_spi_chk
    import lrs_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cs_s,
    input loop_mode_e          mode,
    input logic                w0,
    input logic                w1,
    input logic [ADDR_W-1:0]   cur_addr,
    input logic [ADDR_W-1:0]   next_addr,
    input logic                load,
    input logic [SAMPLE_W-1:0] hold0,
    input logic [SAMPLE_W-1:0] hold1,
    input phase_e              phase,
    input logic [2:0]          bit_cnt
);
    // R3
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LOOP_HOLD) |-> (next_addr == cur_addr));

    // R4
    group_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LOOP_GROUP) |-> (next_addr[3:2] == cur_addr[3:2]));

    // R5
    type_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LOOP_TYPE) |-> (next_addr[3] == cur_addr[3]));

    // R8
    skip_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != LOOP_HOLD) |-> (next_addr != 4'h3 && next_addr != 4'h7));

    // R7
    skip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != LOOP_HOLD) |-> ((w0 || next_addr != 4'h2) && (w1 || next_addr != 4'h6)));

    // R13
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(hold0) && $stable(hold1)));

    // R12
    cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (phase == PH_CMD && bit_cnt == 3'd0));
endmodule

bind loop_seq_spi loop_seq_spi_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .mode     (eff_mode),
    .w0       (eff_w0),
    .w1       (eff_w1),
    .cur_addr (st_q.addr),
    .next_addr(step_next),
    .load     (sample_load),
    .hold0    (u_rf.hold_q[0]),
    .hold1    (u_rf.hold_q[1]),
    .phase    (st_q.phase),
    .bit_cnt  (st_q.bit_cnt)
);

// File: tb/loop_seq_spi_tb.sv
module loop_seq_spi_tb_top;
    localparam int HALF = 8;
    // cfg byte, start address, six expected addresses (first in top nibble)
    localparam logic [35:0] VEC [10] = '{
        {8'h80, 4'h0, 24'h014501},   // R5 R7 type, both 16-bit
        {8'h83, 4'h0, 24'h012456},   // R5 R8 type, both 24-bit
        {8'h82, 4'h0, 24'h012450},   // R7 ch0 wide only
        {8'h00, 4'h5, 24'h555555},   // R3 hold
        {8'h40, 4'h4, 24'h454545},   // R4 group, 16-bit
        {8'h43, 4'hD, 24'hDEFCDE},   // R4 group in calibration
        {8'hC3, 4'hD, 24'hDEF012},   // R6 map wrap
        {8'hC0, 4'h5, 24'h589ABC},   // R6 R8 map, skips 6 and 7
        {8'h80, 4'h9, 24'h9AB89A},   // R5 config type wrap
        {8'h81, 4'h4, 24'h456014}    // R7 ch1 wide only
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, load = 1'b0;
    logic        miso;
    logic [23:0] ch0 = 24'hA1B2C3, ch1 = 24'hD4E5F6;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    loop_seq_spi dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .sample_load(load),
        .ch0_sample(ch0), .ch1_sample(ch1)
    );

    function automatic logic [7:0] model(input logic [3:0] a, input logic [7:0] cfg);
        case (a)
            4'h0: return 8'hA1;  4'h1: return 8'hB2;  4'h2: return 8'hC3;
            4'h4: return 8'hD4;  4'h5: return 8'hE5;  4'h6: return 8'hF6;
            4'h8: return cfg;    4'h9: return 8'h11;  4'hA: return 8'h22;
            4'hB: return 8'h33;  4'hC: return 8'h44;  4'hD: return 8'h55;
            4'hE: return 8'h66;  4'hF: return 8'h77;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] o, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = o[i];
            repeat (HALF) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic start_x();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic stop_x();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic cmd(input logic [3:0] a, input logic rd);
        logic [7:0] junk;
        start_x();
        xbits({3'b101, a, rd}, 8, junk);   // upper bits set: must be ignored (R1)
    endtask

    task automatic wr1(input logic [3:0] a, input logic [7:0] v);
        logic [7:0] junk;
        cmd(a, 1'b0);
        xbits(v, 8, junk);
        stop_x();
    endtask

    task automatic rd1(input logic [3:0] a, output logic [7:0] v);
        cmd(a, 1'b1);
        xbits(8'h00, 8, v);
        stop_x();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, junk;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 miso idle", {7'h0, miso}, 8'h00);
        rd1(4'h8, v);  check("R9 cfg reset", v, 8'h80);
        rd1(4'h9, v);  check("R9 cfg1 reset", v, 8'h00);
        rd1(4'h4, v);  check("R9 holder reset", v, 8'h00);

        load = 1'b1; @(negedge clk); load = 1'b0;
        ch0 = 24'h0; ch1 = 24'h0;      // later changes must not reach the holders
        rd1(4'h0, v);  check("R13 ch0 upper", v, 8'hA1);
        rd1(4'h6, v);  check("R13 ch1 lower", v, 8'hF6);

        // R10 fill configuration and calibration in two bursts
        cmd(4'h8, 1'b0);
        xbits(8'h80, 8, junk); xbits(8'h11, 8, junk);
        xbits(8'h22, 8, junk); xbits(8'h33, 8, junk);
        stop_x();
        cmd(4'hC, 1'b0);
        xbits(8'h44, 8, junk); xbits(8'h55, 8, junk);
        xbits(8'h66, 8, junk); xbits(8'h77, 8, junk);
        stop_x();

        for (int n = 0; n < 10; n++) begin
            logic [7:0] cfg;
            logic [3:0] st;
            logic [23:0] seq;
            {cfg, st, seq} = VEC[n];
            wr1(4'h8, cfg);
            cmd(st, 1'b1);
            for (int k = 0; k < 6; k++) begin
                logic [3:0] a;
                a = seq[23 - 4*k -: 4];
                xbits(8'h00, 8, v);
                check($sformatf("R2 vec%0d byte%0d", n, k), v, model(a, cfg));
            end
            stop_x();
        end

        // R11 writes to channel data ignored, counter still advances
        wr1(4'h8, 8'hC0);
        cmd(4'h5, 1'b0);
        xbits(8'hFF, 8, junk); xbits(8'hC0, 8, junk); xbits(8'h99, 8, junk);
        stop_x();
        rd1(4'h9, v);  check("R11 counter advanced", v, 8'h99);
        rd1(4'h5, v);  check("R11 data untouched", v, 8'hE5);

        // R10 new hold mode written into 0x08 steers the next step
        cmd(4'h8, 1'b0);
        xbits(8'h00, 8, junk); xbits(8'h83, 8, junk);
        stop_x();
        rd1(4'h8, v);  check("R10 cfg rewritten", v, 8'h83);
        rd1(4'h9, v);  check("R10 neighbour kept", v, 8'h99);

        // R12 partial byte discarded on chip select rise
        cmd(4'hC, 1'b0);
        xbits(8'h0F, 4, junk);
        stop_x();
        rd1(4'hC, v);  check("R12 partial dropped", v, 8'h44);
        check("R12 miso idle", {7'h0, miso}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule